// File: doc/BRIEF.md
# Port-Size Data Beat Sequencer

This block runs the data tenure of a split-transaction bus whose external data port can be narrower than the transaction. A request carries a byte size, a burst flag and up to 256 bits of write data. The block latches the request and cuts it into port-sized pieces. Each piece goes out on the upper byte lanes of the port, most significant byte first, with a per-piece data-valid strobe. A transfer-acknowledge qualifier rides on the strobes that close a single-beat transfer or one 64-bit beat of a burst.

A piece moves only in a cycle where the data bus grant and the slave's ready are both high, so wait cycles leave the port unchanged. The data tenure may begin before address-acknowledge has been seen. Pieces that carry no acknowledge may flow early. A piece that would carry an acknowledge is held until the cycle after address-acknowledge, so it never lands inside the retry window. A request with a size code outside the legal set produces a one-cycle error pulse and no pieces.

Top module: `pbeat_seq`

## Requirements
- R1: Port width code `port_sel` is 0=8, 1=16, 2=32, 3=64 bits. Single-beat size code `req_size` is 0=1, 1=2, 2=4, 3=8, 4=16, 5=24 bytes. A single-beat transfer of S bytes on a P-byte port is sent as max(1, S/P) strobes.
- R2: With `req_burst`=1 the size code is ignored and 32 bytes move as 32/P strobes. `xfer_ack` is asserted on every strobe that completes 8 bytes, giving exactly four acknowledges, with the last on the final strobe.
- R3: A single-beat transfer asserts `xfer_ack` exactly once, together with its final strobe.
- R4: `beat_vld` is high only while `busy`, `dbus_grant` and `slv_ready` are all high. In any busy cycle without a strobe, `port_dq` keeps its value into the next cycle while `busy` stays high.
- R5: Transaction data sits in the low S bytes of `req_wdata`. Byte 0 of the transaction is its most significant byte. Strobe k carries transaction bytes k*P up to k*P+min(S,P)-1 on lanes `port_dq[63:56]`, `[55:48]` and onward in that order. All other lanes read zero.
- R6: No `xfer_ack` occurs before the cycle after `aack` is first seen high during the tenure. A strobe that would carry an acknowledge waits for that cycle, while strobes without one may proceed earlier.
- R7: A single-beat request with size code 6 or 7 raises `err` for exactly one cycle, in the cycle after the request. `busy` stays low and no strobe is produced.
- R8: After reset, `busy`, `beat_vld`, `xfer_ack` and `err` are low and `port_dq` is zero.
- R9: A `req_valid` that arrives while `busy` is high is ignored. The running transfer is unaffected and no new tenure follows.
- R10: `busy` rises in the cycle after an accepted legal request and falls in the cycle after the final strobe. Outside `busy`, `port_dq` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_burst | input | 1 | Burst request (32 bytes) |
| req_size | input | 3 | Single-beat size code |
| req_wdata | input | 256 | Write data, transaction in low bytes |
| port_sel | input | 2 | External port width code |
| aack | input | 1 | Address-acknowledge pulse |
| dbus_grant | input | 1 | Data bus grant |
| slv_ready | input | 1 | Slave ready for a piece |
| busy | output | 1 | Data tenure in progress |
| beat_vld | output | 1 | Per-piece data-valid strobe |
| xfer_ack | output | 1 | Transfer-acknowledge qualifier |
| err | output | 1 | Illegal request pulse |
| port_dq | output | 64 | Port data, big-endian lanes |

## Verification
The assertions assume that `aack` pulses at most once per tenure, and only after the request cycle. They also assume the port width code is not changed during a tenure and that every request carries a legal or deliberately illegal code. The directed stimulus raises `aack` once, a chosen number of cycles after the request. It holds `port_sel` for the whole transaction and drops grant and ready on fixed cyclic patterns. It also sends one deliberate mid-tenure request to probe the ignore rule.

// File: rtl/pbeat_pkg.sv
package pbeat_pkg;
  localparam int CNT_W = 6;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t txn_bytes(input logic burst, input logic [2:0] sz);
    if (burst) return cnt_t'(32);
    case (sz)
      3'd0: return cnt_t'(1);
      3'd1: return cnt_t'(2);
      3'd2: return cnt_t'(4);
      3'd3: return cnt_t'(8);
      3'd4: return cnt_t'(16);
      3'd5: return cnt_t'(24);
      default: return cnt_t'(0);
    endcase
  endfunction

  function automatic logic txn_legal(input logic burst, input logic [2:0] sz);
    return burst || (sz < 3'd6);
  endfunction

  function automatic logic [3:0] port_bytes(input logic [1:0] p);
    return 4'd1 << p;
  endfunction

  function automatic cnt_t beat_total(input cnt_t sb, input logic [1:0] p);
    cnt_t t;
    t = sb >> p;
    return (t == '0) ? cnt_t'(1) : t;
  endfunction

  function automatic cnt_t ack_stride(input logic burst, input cnt_t sb, input logic [1:0] p);
    return burst ? (cnt_t'(8) >> p) : beat_total(sb, p);
  endfunction

  function automatic logic [3:0] lane_bytes(input cnt_t sb, input logic [1:0] p);
    logic [3:0] pb;
    pb = port_bytes(p);
    return (sb < cnt_t'(pb)) ? sb[3:0] : pb;
  endfunction
endpackage

// File: rtl/pbeat_plan.sv
module pbeat_plan
  import pbeat_pkg::*;
(
  input  logic       burst,
  input  logic [2:0] sz,
  input  logic [1:0] psel,
  output logic       legal,
  output cnt_t       sb,
  output cnt_t       total,
  output cnt_t       stride,
  output logic [3:0] pb,
  output logic [3:0] lane_b
);
  always_comb begin
    legal  = txn_legal(burst, sz);
    sb     = txn_bytes(burst, sz);
    total  = beat_total(sb, psel);
    stride = ack_stride(burst, sb, psel);
    pb     = port_bytes(psel);
    lane_b = lane_bytes(sb, psel);
  end
endmodule

// File: rtl/pbeat_ctrl.sv
module pbeat_ctrl
  import pbeat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic legal,
  input  cnt_t total_in,
  input  cnt_t stride_in,
  input  logic aack,
  input  logic grant,
  input  logic ready,
  output logic busy,
  output logic load,
  output logic beat_vld,
  output logic ack,
  output logic err
);
  cnt_t tot_q, str_q, cnt_q, sub_q;
  logic win_q;
  logic accept, ack_slot, last_beat;

  assign accept    = req_valid && !busy;
  assign load      = accept && legal;
  assign ack_slot  = (sub_q == str_q - cnt_t'(1));
  assign last_beat = (cnt_q == tot_q - cnt_t'(1));
  assign beat_vld  = busy && grant && ready && (!ack_slot || win_q);
  assign ack       = beat_vld && ack_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      tot_q <= '0;
      str_q <= '0;
      cnt_q <= '0;
      sub_q <= '0;
      win_q <= 1'b0;
      err   <= 1'b0;
    end else begin
      err <= accept && !legal;
      if (load) begin
        busy  <= 1'b1;
        tot_q <= total_in;
        str_q <= stride_in;
        cnt_q <= '0;
        sub_q <= '0;
        win_q <= 1'b0;
      end else if (busy) begin
        if (aack) win_q <= 1'b1;
        if (beat_vld) begin
          cnt_q <= cnt_q + cnt_t'(1);
          sub_q <= ack_slot ? '0 : sub_q + cnt_t'(1);
          if (last_beat) begin
            busy  <= 1'b0;
            win_q <= 1'b0;
          end
        end
      end
    end
  end

  // R4: a strobe needs grant and ready
  a_r4_strobe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld |-> (grant && ready && busy));
  // R6: no acknowledge in the cycle of the first address-acknowledge
  a_r6_no_ack_in_aack: assert property (@(posedge clk) disable iff (!rst_n)
    (aack && !win_q) |-> !ack);
  // R6: never an acknowledge in the first busy cycle
  a_r6_no_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ack);
  // R10: beat counter stays inside the transfer
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < tot_q));
  // R7: error pulse only when idle
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  // R9: a request during a tenure leaves its plan untouched
  a_r9_plan_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(tot_q) && $stable(str_q)));
endmodule

// File: rtl/pbeat_lanes.sv
module pbeat_lanes
  import pbeat_pkg::*;
#(
  parameter int LINE_W = 256,
  parameter int PORT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              active,
  input  logic [LINE_W-1:0] wdata,
  input  cnt_t              sb,
  input  logic [3:0]        pb,
  input  logic [3:0]        lane_b,
  output logic [PORT_W-1:0] port_dq
);
  logic [LINE_W-1:0] sreg;
  logic [3:0] step_q, lane_q;
  logic [PORT_W-1:0] head, mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg   <= '0;
      step_q <= '0;
      lane_q <= '0;
    end else if (load) begin
      sreg   <= wdata << (LINE_W - 8 * int'(sb));
      step_q <= pb;
      lane_q <= lane_b;
    end else if (adv) begin
      sreg <= sreg << (8 * int'(step_q));
    end
  end

  assign head    = sreg[LINE_W-1 -: PORT_W];
  assign mask    = {PORT_W{1'b1}} << (PORT_W - 8 * int'(lane_q));
  assign port_dq = active ? (head & mask) : '0;

  // R4: data holds through wait cycles
  a_r4_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !adv) |=> (!active || $stable(port_dq)));
  // R10: port is quiet outside a tenure
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (port_dq == '0));
endmodule

// File: rtl/pbeat_seq.sv
module pbeat_seq
  import pbeat_pkg::*;
#(
  parameter int LINE_W = 256,
  parameter int PORT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_burst,
  input  logic [2:0]        req_size,
  input  logic [LINE_W-1:0] req_wdata,
  input  logic [1:0]        port_sel,
  input  logic              aack,
  input  logic              dbus_grant,
  input  logic              slv_ready,
  output logic              busy,
  output logic              beat_vld,
  output logic              xfer_ack,
  output logic              err,
  output logic [PORT_W-1:0] port_dq
);
  logic       legal, load;
  cnt_t       sb, total, stride;
  logic [3:0] pb, lane_b;

  pbeat_plan u_plan (
    .burst(req_burst), .sz(req_size), .psel(port_sel),
    .legal(legal), .sb(sb), .total(total), .stride(stride),
    .pb(pb), .lane_b(lane_b)
  );

  pbeat_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .legal(legal),
    .total_in(total), .stride_in(stride), .aack(aack),
    .grant(dbus_grant), .ready(slv_ready),
    .busy(busy), .load(load), .beat_vld(beat_vld), .ack(xfer_ack), .err(err)
  );

  pbeat_lanes #(.LINE_W(LINE_W), .PORT_W(PORT_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(beat_vld), .active(busy),
    .wdata(req_wdata), .sb(sb), .pb(pb), .lane_b(lane_b), .port_dq(port_dq)
  );

  // R3: an acknowledge always rides on a strobe
  a_r3_ack_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> beat_vld);
  // R7: illegal request never starts a tenure
  a_r7_err_no_tenure: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !beat_vld);
endmodule

// File: tb/tb_pbeat_seq.sv
`timescale 1ns/1ps
module tb_pbeat_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_burst = 1'b0;
  logic [2:0] req_size = '0;
  logic [255:0] req_wdata = '0;
  logic [1:0] port_sel = '0;
  logic aack = 1'b0, dbus_grant = 1'b0, slv_ready = 1'b0;
  logic busy, beat_vld, xfer_ack, err;
  logic [63:0] port_dq;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  pbeat_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_burst(req_burst),
    .req_size(req_size), .req_wdata(req_wdata), .port_sel(port_sel),
    .aack(aack), .dbus_grant(dbus_grant), .slv_ready(slv_ready),
    .busy(busy), .beat_vld(beat_vld), .xfer_ack(xfer_ack), .err(err),
    .port_dq(port_dq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int size_of(input bit burst, input int sz);
    if (burst) return 32;
    case (sz)
      0: return 1; 1: return 2; 2: return 4; 3: return 8; 4: return 16; 5: return 24;
      default: return 0;
    endcase
  endfunction

  // one transfer: aack in cycle aack_at, stall pattern mode, optional mid-tenure poke (R9)
  task automatic run_txn(input bit burst, input int sz, input int pt, input int aack_at,
                         input int mode, input bit poke, input int seed);
    int s, p, n, k, cyc, acks, lanes;
    bit passed, slot, ev, g, r;
    logic [255:0] wd;
    logic [63:0] exp_dq;
    s = size_of(burst, sz);
    p = 1 << pt;
    n = (s / p < 1) ? 1 : s / p;
    lanes = (s < p) ? s : p;
    wd = '0;
    for (int i = 0; i < s; i++) wd[i*8 +: 8] = 8'(i * 29 + seed * 7 + 3);
    @(negedge clk);
    req_valid = 1'b1; req_burst = burst; req_size = 3'(sz); port_sel = 2'(pt);
    req_wdata = wd; aack = 1'b0; dbus_grant = 1'b0; slv_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; cyc = 1; acks = 0; passed = 0;
    while (k < n && cyc < 400) begin
      aack = (cyc == aack_at);
      case (mode)
        1: begin g = (cyc % 3 != 0); r = 1'b1; end
        2: begin g = (cyc % 7 != 5); r = (cyc % 4 != 1); end
        default: begin g = 1'b1; r = 1'b1; end
      endcase
      dbus_grant = g; slv_ready = r;
      if (poke && cyc == 2) begin
        req_valid = 1'b1; req_burst = 1'b1; req_wdata = '1;
      end else begin
        req_valid = 1'b0; req_wdata = wd;
      end
      #2;
      check(busy === 1'b1, "R10 busy during tenure", 64'(busy), 64'd1);
      slot = burst ? (((k + 1) * p) % 8 == 0) : (k == n - 1);
      ev = g && r && (!slot || passed);
      check(beat_vld === ev, "R4/R6 strobe timing", 64'(beat_vld), 64'(ev));
      if (ev) begin
        exp_dq = '0;
        for (int j = 0; j < lanes; j++) exp_dq[63 - 8*j -: 8] = wd[(s - 1 - (k*p + j)) * 8 +: 8];
        check(port_dq === exp_dq, "R5 lane data", port_dq, exp_dq);
        check(xfer_ack === slot, burst ? "R2 burst ack" : "R3 single ack", 64'(xfer_ack), 64'(slot));
        if (xfer_ack === 1'b1) begin
          acks++;
          check(passed, "R6 ack after window", 64'(cyc), 64'(aack_at + 1));
        end
        k++;
      end else if (busy) begin
        exp_dq = port_dq;
        @(posedge clk); #1;
        if (busy) check(port_dq === exp_dq, "R4 hold on wait", port_dq, exp_dq);
        @(negedge clk); if (aack) passed = 1; cyc++;
        continue;
      end
      if (aack) passed = 1;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0; aack = 1'b0; req_wdata = '0;
    #2;
    check(k == n, "R1 strobe count", 64'(k), 64'(n));
    check(acks == (burst ? 4 : 1), burst ? "R2 four acks" : "R3 one ack", 64'(acks), burst ? 64'd4 : 64'd1);
    check(busy === 1'b0, poke ? "R9 poke ignored" : "R10 busy falls", 64'(busy), 64'd0);
    check(port_dq === 64'd0, "R10 idle port zero", port_dq, 64'd0);
    @(negedge clk);
    check(busy === 1'b0 && beat_vld === 1'b0, "R9 no second tenure", 64'(busy), 64'd0);
  endtask

  task automatic t_reset;
    check(busy === 1'b0, "R8 busy", 64'(busy), 64'd0);
    check(beat_vld === 1'b0 && xfer_ack === 1'b0, "R8 strobes", 64'(beat_vld), 64'd0);
    check(err === 1'b0, "R8 err", 64'(err), 64'd0);
    check(port_dq === 64'd0, "R8 dq", port_dq, 64'd0);
  endtask

  task automatic t_sweep;
    int idx = 0;
    for (int pt = 0; pt < 4; pt++) begin
      for (int sz = 0; sz < 6; sz++) begin
        run_txn(1'b0, sz, pt, 1 + idx % 4, idx % 3, 1'b0, idx);
        idx++;
      end
      run_txn(1'b1, 0, pt, 1 + idx % 4, idx % 3, 1'b0, idx);
      idx++;
    end
  endtask

  task automatic t_late_window;
    run_txn(1'b1, 0, 3, 12, 0, 1'b0, 50);  // R6 every strobe acks, all wait
    run_txn(1'b1, 0, 0, 20, 0, 1'b0, 51);  // R6 early strobes flow, eighth waits
    run_txn(1'b0, 0, 0, 8, 2, 1'b0, 52);   // R6 single byte held
  endtask

  task automatic t_illegal;
    for (int sz = 6; sz < 8; sz++) begin
      @(negedge clk);
      req_valid = 1'b1; req_burst = 1'b0; req_size = 3'(sz);
      dbus_grant = 1'b1; slv_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      #2;
      check(err === 1'b1, "R7 err pulse", 64'(err), 64'd1);
      check(busy === 1'b0 && beat_vld === 1'b0, "R7 no tenure", 64'(busy), 64'd0);
      @(negedge clk); #2;
      check(err === 1'b0, "R7 err one cycle", 64'(err), 64'd0);
    end
  endtask

  task automatic t_busy_ignore;
    run_txn(1'b0, 4, 2, 3, 0, 1'b1, 60);  // R9 R1 128 bits on 32-bit port
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    t_sweep();
    t_late_window();
    t_illegal();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule